// File: doc/BRIEF.md
# Strobed Overvoltage Fault Qualifier

This block decides whether a converter output is truly overvoltage. A comparator outside the block watches the auxiliary-winding voltage. That voltage follows the output only while the power switch is off, and only after the turn-off ringing has died away. The block therefore looks at the comparator only inside a short window that opens a fixed delay after each turn-off. It counts switching cycles in which the comparator tripped inside that window. Any cycle without a trip clears the count, so noise on a single cycle cannot cause a fault.

When `RUN_LEN` tripped cycles arrive in an unbroken run, the block raises a one-clock fault pulse. A supervisor uses that pulse to stop switching and start the restart sequence. After the fault, the counter stays at zero until the block is reset.

All timing is measured in clocks of `clk`. `STROBE_CYC` sets the delay from turn-off to the opening of the window, and `WINDOW_CYC` sets how long the window stays open. With a 200 MHz clock, the defaults give about 2 µs and 0.5 µs.

Top module: `ovp_strobe_qualifier`

## Requirements
- R1: After reset, `trip_count` is 0 and `fault_pulse` is low.
- R2: `cmp_raw` passes through a two-flop synchroniser, so the block sees its value two clocks late. A synchronised high counts only when `gate_on` is low and the clocks since turn-off, counted from 0 at the first low clock, lie in the range [`STROBE_CYC`, `STROBE_CYC`+`WINDOW_CYC`). Highs before the window, after the window, or while `gate_on` is high have no effect on `trip_count`.
- R3: A cycle counts as tripped if the synchronised comparator is high on at least one clock inside the window. Each tripped cycle raises `trip_count` by 1 at the clock edge where `cycle_start` is sampled high.
- R4: A cycle with no trip sets `trip_count` to 0 at its `cycle_start` edge.
- R5: If the off-time ends before the window opens, the cycle counts as not tripped.
- R6: If `cycle_start` is high on a clock that is itself inside the window and the synchronised comparator is high on that clock, the trip counts for the cycle that is ending.
- R7: The `cycle_start` edge that completes `RUN_LEN` consecutive tripped cycles drives `fault_pulse` high for exactly one clock, starting just after that edge. At the same edge `trip_count` returns to 0.
- R8: After a fault, `trip_count` stays at 0 and `fault_pulse` stays low until reset, even if more cycles trip.
- R9: `trip_count` changes only at edges where `cycle_start` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gate_on | input | 1 | High while the power switch is on |
| cycle_start | input | 1 | One-clock strobe that ends one switching cycle and begins the next |
| cmp_raw | input | 1 | Asynchronous comparator output, high when the voltage is above threshold |
| fault_pulse | output | 1 | One-clock pulse when an overvoltage fault is declared |
| trip_count | output | CNT_W | Number of consecutive tripped cycles so far |

## Verification
Two things can happen on the same clock. The cycle-end evaluation can fall on a clock that is inside the sampling window, so a trip sampled on that clock must still count for the cycle that is ending. The bench provokes this by asserting `cycle_start` while the gate is still low. It does this once on the first window clock, where the trip must be counted, and once on the clock just before the window opens, where the cycle must count as clean. The bench also lines up the fourth consecutive trip with the evaluation edge. It then checks that the fault pulse and the return of the counter to zero appear together, and that later tripped cycles change neither of them.

// File: rtl/ovp_strobe_qualifier.sv
module ovp_strobe_qualifier #(
  parameter int STROBE_CYC = 400,
  parameter int WINDOW_CYC = 100,
  parameter int RUN_LEN    = 4,
  localparam int CNT_W     = (RUN_LEN > 2) ? $clog2(RUN_LEN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_on,
  input  logic             cycle_start,
  input  logic             cmp_raw,
  output logic             fault_pulse,
  output logic [CNT_W-1:0] trip_count
);

  localparam int OFF_MAX = STROBE_CYC + WINDOW_CYC;
  localparam int OFF_W   = $clog2(OFF_MAX + 1);
  localparam logic [OFF_W-1:0] WIN_LO   = OFF_W'(STROBE_CYC);
  localparam logic [OFF_W-1:0] WIN_HI   = OFF_W'(OFF_MAX);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RUN_LEN - 1);

  logic             sync_a, cmp_s;
  logic [OFF_W-1:0] off_cnt;
  logic             trip_seen, fault_latched;
  logic             in_window, sample_hit, cycle_tripped;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {cmp_s, sync_a} <= 2'b00;
    else        {cmp_s, sync_a} <= {sync_a, cmp_raw};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              off_cnt <= '0;
    else if (gate_on)        off_cnt <= '0;
    else if (off_cnt != WIN_HI) off_cnt <= off_cnt + 1'b1;

  assign in_window     = !gate_on && (off_cnt >= WIN_LO) && (off_cnt < WIN_HI);
  assign sample_hit    = in_window && cmp_s;
  assign cycle_tripped = trip_seen || sample_hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)           trip_seen <= 1'b0;
    else if (cycle_start) trip_seen <= 1'b0;
    else if (sample_hit)  trip_seen <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      trip_count    <= '0;
      fault_latched <= 1'b0;
      fault_pulse   <= 1'b0;
    end else begin
      fault_pulse <= 1'b0;
      if (cycle_start && !fault_latched) begin
        if (!cycle_tripped)              trip_count <= '0;
        else if (trip_count == CNT_LAST) begin
          trip_count    <= '0;
          fault_latched <= 1'b1;
          fault_pulse   <= 1'b1;
        end else                         trip_count <= trip_count + 1'b1;
      end
    end

  p_fault_one_clk_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse |=> !fault_pulse);

  p_count_below_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trip_count <= CNT_LAST);

  p_hold_after_fault_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_latched |=> (trip_count == '0) && !fault_pulse);

  p_count_only_at_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cycle_start |=> $stable(trip_count));

  p_trip_only_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trip_seen) |-> $past(!gate_on));

endmodule

// File: tb/ovp_strobe_qualifier_tb_top.sv
module ovp_strobe_qualifier_tb_top;
  localparam int SC = 8, WC = 4, RL = 4, ON_LEN = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic gate_on = 1'b1, cycle_start = 1'b0, cmp_raw = 1'b0;
  logic fault_pulse;
  logic [1:0] trip_count;
  int total = 0, bad = 0, faults = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ovp_strobe_qualifier #(.STROBE_CYC(SC), .WINDOW_CYC(WC), .RUN_LEN(RL)) dut_i (
    .clk(clk), .rst_n(rst_n), .gate_on(gate_on), .cycle_start(cycle_start),
    .cmp_raw(cmp_raw), .fault_pulse(fault_pulse), .trip_count(trip_count));

  always @(negedge clk) if (rst_n && fault_pulse) faults++;

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  // one switching cycle: on-time, off clocks k=0..off_len-1, then the
  // cycle_start clock at k=off_len with gate still low
  task automatic run_cycle(input int off_len, input int c_from, input int c_to, input bit cmp_on);
    gate_on = 1'b1;
    for (int i = 0; i < ON_LEN; i++) begin
      cmp_raw = cmp_on;
      @(negedge clk);
    end
    gate_on = 1'b0;
    for (int k = 0; k <= off_len; k++) begin
      cmp_raw = (k >= c_from) && (k < c_to);
      cycle_start = (k == off_len);
      @(negedge clk);
    end
    cycle_start = 1'b0;
    cmp_raw = 1'b0;
    gate_on = 1'b1;
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    gate_on = 1'b1; cycle_start = 1'b0; cmp_raw = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    do_reset();
    check("R1 count", trip_count, 0);
    check("R1 fault", fault_pulse, 0);
  endtask

  task automatic t_run_and_clear;
    run_cycle(20, 0, 20, 0); check("R3 first trip", trip_count, 1);
    run_cycle(20, 0, 20, 0); check("R3 second trip", trip_count, 2);
    run_cycle(20, 14, 18, 0); check("R4 clean cycle clears", trip_count, 0);
  endtask

  task automatic t_outside_window;
    run_cycle(20, 0, 20, 0);
    run_cycle(20, 0, 5, 0);  check("R2 early pulse ignored", trip_count, 0);
    run_cycle(20, 0, 20, 0);
    run_cycle(20, 0, 0, 1);  check("R2 high during on-time ignored", trip_count, 0);
  endtask

  task automatic t_window_edges;
    run_cycle(20, 6, 7, 0);   check("R2 first window clock", trip_count, 1);
    run_cycle(20, 9, 10, 0);  check("R2 last window clock", trip_count, 2);
    run_cycle(20, 10, 11, 0); check("R2 clock after window", trip_count, 0);
  endtask

  task automatic t_short_off;
    run_cycle(20, 0, 20, 0);
    run_cycle(7, 0, 20, 0); check("R5 off-time ends early", trip_count, 0);
    run_cycle(8, 0, 20, 0); check("R6 trip on cycle_start clock", trip_count, 1);
  endtask

  task automatic t_fault;
    int f0;
    run_cycle(20, 0, 20, 0); // clear any partial run first
    run_cycle(20, 14, 18, 0);
    f0 = faults;
    for (int n = 1; n < RL; n++) run_cycle(20, 0, 20, 0);
    check("R3 count before fault", trip_count, RL - 1);
    check("R7 no fault yet", faults - f0, 0);
    run_cycle(20, 0, 20, 0);
    check("R7 count cleared with fault", trip_count, 0);
    @(negedge clk);
    check("R7 single fault pulse", faults - f0, 1);
    for (int n = 0; n < RL + 1; n++) run_cycle(20, 0, 20, 0);
    check("R8 count held", trip_count, 0);
    check("R8 no further pulse", faults - f0, 1);
  endtask

  task automatic t_rearm;
    do_reset();
    check("R1 fault cleared", fault_pulse, 0);
    run_cycle(20, 0, 20, 0);
    check("R9 counting resumes", trip_count, 1);
    gate_on = 1'b0; cmp_raw = 1'b1;
    repeat (20) @(negedge clk);
    check("R9 no change without cycle_start", trip_count, 1);
    cmp_raw = 1'b0; gate_on = 1'b1;
  endtask

  initial begin
    t_reset();
    t_run_and_clear();
    t_outside_window();
    t_window_edges();
    t_short_off();
    t_fault();
    t_rearm();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog got=timeout exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule